// File: doc/BRIEF.md
# Lockable Pin Control Register Bank

This block holds the attribute settings of the 32 pins of one port. Each pin owns one register behind a small register bus. The register stores the pull enable and pull direction, the slew choice, the passive input filter enable, the open-drain enable, the drive strength and a 3-bit function select. Every one of these settings is also driven out continuously as a plain per-pin output, for the pad ring and the function router to use.

A lock bit in each register makes its low half read-only until the next reset. Two broadcast addresses copy one 16-bit image into any chosen subset of pins 0-15, or of pins 16-31, in a single bus access. A broadcast still skips every pin that is locked.

Register image (bits 31:16 and unlisted bits always read 0): bit 0 pull direction (0 down, 1 up), bit 1 pull enable, bit 2 slew (0 fast, 1 slow), bit 4 passive filter enable, bit 5 open-drain enable, bit 6 drive (0 low, 1 high), bits 10:8 function (0 disabled/analog, 1 general-purpose I/O, 2-7 alternates), bit 15 lock. Addresses 0-31 select a pin register, 32 is the low broadcast and 33 is the high broadcast. For a broadcast, bus_wdata[31:16] is the pin mask and bus_wdata[15:0] is the image.

Top module: `pin_ctrl_bank`

## Requirements
- R1: While reset is asserted and after it is released, every output is 0 and every pin register reads 0.
- R2: A write to address n (0-31) to an unlocked pin stores bits 0,1,2,4,5,6,10:8,15 of bus_wdata in register n after that clock edge; all other bits read back as 0.
- R3: A read issued with bus_rd at a clock edge presents the register on bus_rdata after that edge; reads of addresses 32 and above return 0, and bus_rdata is 0 after any cycle without bus_rd.
- R4: The outputs follow the stored fields: pull_up = bit 0, pull_en = bit 1, slow_slew = bit 2, filt_en = bit 4, open_drain = bit 5, high_drive = bit 6, func_sel[3n+2:3n] = bits 10:8 of pin n.
- R5: Once bit 15 of a pin is 1, no write of any kind changes that pin's register, and the lock bit cannot be cleared except by reset.
- R6: A write that sets bit 15 also stores the other fields carried in the same access.
- R7: A write to address 32 stores bus_wdata[15:0] into pin i (0-15) for each set bus_wdata[16+i]; pins with a clear mask bit are unchanged.
- R8: A write to address 33 stores bus_wdata[15:0] into pin 16+i for each set bus_wdata[16+i]; other pins are unchanged.
- R9: A broadcast write skips a locked pin even when its mask bit is set, while unlocked selected pins are updated.
- R10: Reset clears all locks, so previously locked pins accept writes again.
- R11: When a read and a write to the same pin occur at the same edge, the read returns the contents from before the write.
- R12: Writes to addresses 34 and above change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 32 | Write data (mask in 31:16 for broadcasts) |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| pull_en | output | 32 | Per-pin pull resistor enable |
| pull_up | output | 32 | Per-pin pull direction, 1 = up |
| slow_slew | output | 32 | Per-pin slew, 1 = slow |
| filt_en | output | 32 | Per-pin passive filter enable |
| open_drain | output | 32 | Per-pin open-drain enable |
| high_drive | output | 32 | Per-pin drive strength, 1 = high |
| func_sel | output | 96 | Per-pin function select, 3 bits per pin |

## Verification
A read and a write can hit the same pin register at one edge, and a lock can arrive together with new field values in one access. The bench raises bus_rd and bus_wr together on one pin and expects the scoreboard to receive the old contents, then reads again for the new ones. It also locks a pin with a non-zero image and judges that both the lock and the fields land, and that a later broadcast covering that pin leaves it untouched while its neighbour changes.

// File: rtl/pin_ctrl_pkg.sv
package pin_ctrl_pkg;

  localparam int IMG_W = 16;

  localparam int B_PULL_UP = 0;
  localparam int B_PULL_EN = 1;
  localparam int B_SLOW    = 2;
  localparam int B_FILT    = 4;
  localparam int B_ODRAIN  = 5;
  localparam int B_DRIVE   = 6;
  localparam int B_FUNC    = 8;
  localparam int B_LOCK    = 15;

  typedef struct packed {
    logic       lock;
    logic [2:0] func;
    logic       drive;
    logic       odrain;
    logic       filt;
    logic       slow;
    logic       pull_en;
    logic       pull_up;
  } pin_cfg_t;

  function automatic pin_cfg_t img_to_cfg(input logic [IMG_W-1:0] img);
    pin_cfg_t c;
    c.lock    = img[B_LOCK];
    c.func    = img[B_FUNC +: 3];
    c.drive   = img[B_DRIVE];
    c.odrain  = img[B_ODRAIN];
    c.filt    = img[B_FILT];
    c.slow    = img[B_SLOW];
    c.pull_en = img[B_PULL_EN];
    c.pull_up = img[B_PULL_UP];
    return c;
  endfunction

  function automatic logic [IMG_W-1:0] cfg_to_img(input pin_cfg_t c);
    logic [IMG_W-1:0] img;
    img              = '0;
    img[B_LOCK]      = c.lock;
    img[B_FUNC +: 3] = c.func;
    img[B_DRIVE]     = c.drive;
    img[B_ODRAIN]    = c.odrain;
    img[B_FILT]      = c.filt;
    img[B_SLOW]      = c.slow;
    img[B_PULL_EN]   = c.pull_en;
    img[B_PULL_UP]   = c.pull_up;
    return img;
  endfunction

endpackage

// File: rtl/pcr_wr_decode.sv
module pcr_wr_decode #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 6,
  parameter int HALF     = NUM_PINS / 2
) (
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [HALF-1:0]     bcast_mask,
  output logic [NUM_PINS-1:0] pin_we
);

  localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(NUM_PINS);
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(NUM_PINS + 1);

  logic lo_hit;
  logic hi_hit;

  always_comb begin
    lo_hit = bus_wr && (bus_addr == LO_ADDR);
    hi_hit = bus_wr && (bus_addr == HI_ADDR);
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic own_hit;
    logic grp_hit;
    always_comb own_hit = bus_wr && (bus_addr == ADDR_W'(i));
    if (i < HALF) begin : g_lo
      always_comb grp_hit = lo_hit && bcast_mask[i];
    end else begin : g_hi
      always_comb grp_hit = hi_hit && bcast_mask[i-HALF];
    end
    always_comb pin_we[i] = own_hit || grp_hit;
  end

endmodule

// File: rtl/pcr_pin_slot.sv
module pcr_pin_slot
  import pin_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IMG_W-1:0] wval,
  output pin_cfg_t         cfg
);

  pin_cfg_t cfg_q;
  pin_cfg_t cfg_nxt;
  logic     upd;

  always_comb begin
    upd     = we && !cfg_q.lock;
    cfg_nxt = cfg_q;
    if (upd) cfg_nxt = img_to_cfg(wval);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cfg_q <= '0;
    else if (upd) cfg_q <= cfg_nxt;
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/pcr_read_port.sv
module pcr_read_port
  import pin_ctrl_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 6,
  parameter int PIN_W    = $clog2(NUM_PINS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_rd,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [NUM_PINS-1:0][IMG_W-1:0]  img,
  output logic [31:0]                     bus_rdata
);

  logic [31:0] rdata_q;
  logic [31:0] rdata_nxt;

  always_comb begin
    rdata_nxt = '0;
    if (bus_rd && (bus_addr < ADDR_W'(NUM_PINS)))
      rdata_nxt = {{(32-IMG_W){1'b0}}, img[bus_addr[PIN_W-1:0]]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_nxt;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/pin_ctrl_bank.sv
module pin_ctrl_bank
  import pin_ctrl_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = $clog2(NUM_PINS + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic [NUM_PINS-1:0]   pull_en,
  output logic [NUM_PINS-1:0]   pull_up,
  output logic [NUM_PINS-1:0]   slow_slew,
  output logic [NUM_PINS-1:0]   filt_en,
  output logic [NUM_PINS-1:0]   open_drain,
  output logic [NUM_PINS-1:0]   high_drive,
  output logic [3*NUM_PINS-1:0] func_sel
);

  localparam int HALF = NUM_PINS / 2;

  logic [NUM_PINS-1:0]            pin_we;
  logic [NUM_PINS-1:0]            lock_vec;
  logic [NUM_PINS-1:0][IMG_W-1:0] img;

  pcr_wr_decode #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .HALF     (HALF)
  ) dec_i (
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bcast_mask (bus_wdata[16 +: HALF]),
    .pin_we     (pin_we)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_slot
    pin_cfg_t cfg;
    pcr_pin_slot slot_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (pin_we[i]),
      .wval  (bus_wdata[IMG_W-1:0]),
      .cfg   (cfg)
    );
    always_comb begin
      img[i]           = cfg_to_img(cfg);
      lock_vec[i]      = cfg.lock;
      pull_en[i]       = cfg.pull_en;
      pull_up[i]       = cfg.pull_up;
      slow_slew[i]     = cfg.slow;
      filt_en[i]       = cfg.filt;
      open_drain[i]    = cfg.odrain;
      high_drive[i]    = cfg.drive;
      func_sel[3*i +: 3] = cfg.func;
    end
  end

  pcr_read_port #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
  ) rd_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .img       (img),
    .bus_rdata (bus_rdata)
  );

endmodule

// File: rtl/pin_ctrl_bank_chk.sv
module pin_ctrl_bank_chk #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [31:0]           bus_rdata,
  input logic [NUM_PINS-1:0]   pull_en,
  input logic [NUM_PINS-1:0]   pull_up,
  input logic [NUM_PINS-1:0]   slow_slew,
  input logic [NUM_PINS-1:0]   filt_en,
  input logic [NUM_PINS-1:0]   open_drain,
  input logic [NUM_PINS-1:0]   high_drive,
  input logic [3*NUM_PINS-1:0] func_sel,
  input logic [NUM_PINS-1:0]   lock_vec
);

  logic [3*NUM_PINS-1:0] lock3;
  logic [6*NUM_PINS-1:0] bits_all;
  logic [6*NUM_PINS-1:0] lock6;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_m
    assign lock3[3*i +: 3] = {3{lock_vec[i]}};
  end
  assign bits_all = {pull_en, pull_up, slow_slew, filt_en, open_drain, high_drive};
  assign lock6    = {6{lock_vec}};

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_vec & $past(lock_vec)) == $past(lock_vec));

  // R5
  locked_bits_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bits_all ^ $past(bits_all)) & $past(lock6)) == '0);

  // R5
  locked_func_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((func_sel ^ $past(func_sel)) & $past(lock3)) == '0);

  // R3
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0);

  // R3
  rdata_bcast_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr >= ADDR_W'(NUM_PINS)) |=> bus_rdata == '0);

  // R12
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr > ADDR_W'(NUM_PINS + 1)) |=> ($stable(bits_all) && $stable(func_sel)));

  // R2
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:16] == '0);

endmodule

bind pin_ctrl_bank pin_ctrl_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/pin_ctrl_bank_tb_top.sv
module pin_ctrl_bank_tb_top;

  localparam int N = 32;
  localparam logic [15:0] KEEP = 16'h8777;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_rd;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [N-1:0] pull_en, pull_up, slow_slew, filt_en, open_drain, high_drive;
  logic [3*N-1:0] func_sel;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [15:0] mdl [N];

  typedef struct { logic [31:0] exp; string req; } item_t;
  item_t exp_q [$];

  pin_ctrl_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pull_en(pull_en), .pull_up(pull_up), .slow_slew(slow_slew),
    .filt_en(filt_en), .open_drain(open_drain), .high_drive(high_drive),
    .func_sel(func_sel)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // requirement-level model of one write access
  task automatic model_write(input logic [5:0] a, input logic [31:0] d);
    if (a < 6'(N)) begin
      if (!mdl[a][15]) mdl[a] = d[15:0] & KEEP;
    end else if (a == 6'd32 || a == 6'd33) begin
      for (int i = 0; i < 16; i++) begin
        int p;
        p = (a == 6'd32) ? i : i + 16;
        if (d[16+i] && !mdl[p][15]) mdl[p] = d[15:0] & KEEP;
      end
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) mdl[i] = '0;
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    model_write(a, d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, input string req);
    item_t it;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    it.exp = (a < 6'(N)) ? {16'h0, mdl[a]} : 32'h0;
    it.req = req;
    exp_q.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // R11: read and write one pin at the same edge
  task automatic bus_rw(input logic [5:0] a, input logic [31:0] d, input string req);
    item_t it;
    @(negedge clk);
    bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    it.exp = {16'h0, mdl[a]};
    it.req = req;
    exp_q.push_back(it);
    model_write(a, d);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic check_pins(input string req);
    logic [N-1:0] e_pe, e_pu, e_sl, e_fi, e_od, e_dr;
    logic [3*N-1:0] e_fn;
    for (int i = 0; i < N; i++) begin
      e_pu[i] = mdl[i][0]; e_pe[i] = mdl[i][1]; e_sl[i] = mdl[i][2];
      e_fi[i] = mdl[i][4]; e_od[i] = mdl[i][5]; e_dr[i] = mdl[i][6];
      e_fn[3*i +: 3] = mdl[i][10:8];
    end
    check({req, " pull_en"},    128'(pull_en),    128'(e_pe));
    check({req, " pull_up"},    128'(pull_up),    128'(e_pu));
    check({req, " slow_slew"},  128'(slow_slew),  128'(e_sl));
    check({req, " filt_en"},    128'(filt_en),    128'(e_fi));
    check({req, " open_drain"}, 128'(open_drain), 128'(e_od));
    check({req, " high_drive"}, 128'(high_drive), 128'(e_dr));
    check({req, " func_sel"},   128'(func_sel),   128'(e_fn));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // monitor: pops one expected item per read issued
  initial begin
    forever begin
      bit took;
      @(posedge clk);
      took = bus_rd && rst_n;
      @(negedge clk);
      if (took) begin
        item_t it;
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL scoreboard empty actual=%0h expected=none", bus_rdata);
        end else begin
          it = exp_q.pop_front();
          check(it.req, 128'(bus_rdata), 128'(it.exp));
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    model_reset();
    repeat (2) @(negedge clk);
    check_pins("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_pins("R1 after reset");
    check("R1 rdata", 128'(bus_rdata), 128'h0);
    bus_read(6'd0, "R1 pin0");
    bus_read(6'd31, "R1 pin31");

    // R2 reserved bits drop, R4 field mapping
    bus_write(6'd3, 32'hFFFF_7FFF);
    check_pins("R4 pin3 all fields");
    bus_read(6'd3, "R2 pin3 image");
    bus_write(6'd5, 32'h0000_0503);
    bus_write(6'd9, 32'h0000_0154);
    check_pins("R4 pins5 9");
    bus_read(6'd5, "R2 pin5");
    bus_read(6'd9, "R2 pin9");

    // R3 reads of non-pin addresses
    bus_read(6'd32, "R3 addr32");
    bus_read(6'd33, "R3 addr33");
    bus_read(6'd40, "R3 addr40");
    @(negedge clk);
    check("R3 idle rdata", 128'(bus_rdata), 128'h0);

    // R12 stray write
    bus_write(6'd50, 32'hFFFF_FFFF);
    check_pins("R12 stray write");

    // R7 low broadcast
    bus_write(6'd32, 32'h00F0_0262);
    check_pins("R7 low bcast");
    bus_read(6'd4, "R7 pin4");
    bus_read(6'd3, "R7 pin3 kept");
    bus_read(6'd20, "R7 pin20 kept");

    // R8 high broadcast
    bus_write(6'd33, 32'h8001_0444);
    check_pins("R8 high bcast");
    bus_read(6'd16, "R8 pin16");
    bus_read(6'd31, "R8 pin31");
    bus_read(6'd0, "R8 pin0 kept");

    // R6 lock with fields, R5 frozen
    bus_write(6'd7, 32'h0000_8701);
    bus_read(6'd7, "R6 lock and fields");
    bus_write(6'd7, 32'h0000_0000);
    bus_read(6'd7, "R5 locked single write");
    check_pins("R5 locked pin outputs");

    // R9 broadcast skips locked pin
    bus_write(6'd32, 32'h00C0_0010);
    bus_read(6'd6, "R9 pin6 updated");
    bus_read(6'd7, "R9 pin7 skipped");
    check_pins("R9 outputs");

    // R11 same-edge read and write
    bus_rw(6'd6, 32'h0000_0020, "R11 old value");
    bus_read(6'd6, "R11 new value");

    // sweep all pins
    for (int i = 0; i < N; i++) bus_write(6'(i), 32'((i * 16'h1357) ^ 16'h0A52));
    check_pins("R4 sweep");
    for (int i = 0; i < N; i++) bus_read(6'(i), "R2 sweep");

    // R10 reset clears locks
    do_reset();
    check_pins("R10 after reset");
    bus_write(6'd7, 32'h0000_0202);
    bus_read(6'd7, "R10 pin7 writable");
    check_pins("R10 outputs");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule